// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

This block watches a free-running 64-bit system counter. Software keeps it quiet by writing a refresh port at regular intervals. The time allowed between refreshes is a 48-bit tick count, so the counter's frequency sets how long one tick lasts. Each explicit re-arm sets a private deadline equal to the current counter value plus the offset.

If the deadline passes once, the block raises a level interrupt and arms a second, equal window. The software-visible compare registers are left unchanged when that second window is armed. If the second window also passes without a refresh, the block records the second stage and emits a one-cycle reset request. What the system does with that request lies outside the block.

Access is through two word ports that share one register state:
- A refresh port: refresh, identification.
- A control port: status/enable, offsets, compare values, identification.

Byte offsets are 12 bits wide. Reads are combinational, with no side effects.

Top module: `wdog_two_stage`

## Requirements
- R1: The tick offset is 48 bits wide. Its low 32 bits come from the control register at 0x008, and its upper 16 bits come from bits 15:0 of the register at 0x00C. Bits written above bit 15 at 0x00C are dropped and read back as zero.
- R2: A write to refresh offset 0x000 does four things:
  - It clears status bits 1 and 2.
  - It re-arms the deadline to counter plus offset.
  - It leaves the interrupt level unchanged.
  - It leaves the enable bit unchanged.
- R3: A read of refresh offset 0x000 returns zero and changes no state.
- R4: A write to the control/status register at 0x000 keeps only data bit 0 as the enable bit (status bit 0) and clears status bits 1 and 2. It also drops the interrupt and performs an explicit re-arm.
- R5: A write to 0x008 or 0x00C stores the offset, clears status bits 1 and 2, drops the interrupt and performs an explicit re-arm.
- R6: While the enable bit is 0, no deadline is armed and no expiry happens, whatever the counter does.
- R7: An explicit re-arm with enable set loads the compare registers with the new deadline: low word at 0x010, high word at 0x014.
- R8: The first expiry happens when counter >= deadline while status bit 1 is clear. It sets status bit 1, raises the interrupt and arms a new deadline at counter plus offset. The compare registers keep their old contents.
- R9: An expiry while status bit 1 is set does three things:
  - It sets status bit 2.
  - It pulses the reset request high for exactly one cycle.
  - It disarms the timer.
- R10: The compare registers can be written directly. Such a write changes only what reads back from them, never the armed deadline.
- R11: Offset 0xFFC reads the identification value on both ports. Any other unlisted offset reads zero and ignores writes.
- R12: Reset does the following:
  - It clears status, offsets, compare registers, interrupt and reset request.
  - It leaves the identification value at its parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 64 | Free-running system counter |
| ref_vld | input | 1 | Refresh port access strobe |
| ref_wr | input | 1 | Refresh port write (1) or read (0) |
| ref_addr | input | 12 | Refresh port byte offset |
| ref_rdata | output | 32 | Refresh port read data |
| ctl_vld | input | 1 | Control port access strobe |
| ctl_wr | input | 1 | Control port write (1) or read (0) |
| ctl_addr | input | 12 | Control port byte offset |
| ctl_wdata | input | 32 | Control port write data |
| ctl_rdata | output | 32 | Control port read data |
| irq_o | output | 1 | First-stage interrupt level |
| rst_req_o | output | 1 | Second-stage reset request pulse |

## Verification
The assertions assume the counter moves forward monotonically between re-arms. They also assume a write and an expiry in the same cycle resolve in favour of the write. The stimulus keeps to these assumptions: it sets counter values that only grow within each scenario, and it times refreshes away from the deadline cycle except where priority is the point of the test. Offsets are chosen so that counter plus offset never wraps 64 bits. Some deadlines land above bit 31 so that the upper compare word and the upper offset field carry real values.

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int          ADDR_W   = 12,
  parameter int          OFS_HI_W = 16,
  parameter logic [31:0] ID_VAL   = 32'h0002_0A5D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       cnt_i,
  input  logic              ref_vld,
  input  logic              ref_wr,
  input  logic [ADDR_W-1:0] ref_addr,
  output logic [31:0]       ref_rdata,
  input  logic              ctl_vld,
  input  logic              ctl_wr,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic [31:0]       ctl_wdata,
  output logic [31:0]       ctl_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int CNT_W = 64;
  localparam int OFS_W = 32 + OFS_HI_W;
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] A_OFS_LO = ADDR_W'('h008);
  localparam logic [ADDR_W-1:0] A_OFS_HI = ADDR_W'('h00C);
  localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'('h010);
  localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'('h014);
  localparam logic [ADDR_W-1:0] A_ID     = ADDR_W'('hFFC);
  localparam logic [ADDR_W-1:0] A_KICK   = ADDR_W'('h000);

  logic                en_q, s1_q, s2_q, armed_q;
  logic [31:0]         ofs_lo_q;
  logic [OFS_HI_W-1:0] ofs_hi_q;
  logic [CNT_W-1:0]    dl_q, cmp_q;

  wire ctl_w  = ctl_vld & ctl_wr;
  wire w_ctrl = ctl_w && ctl_addr == A_CTRL;
  wire w_olo  = ctl_w && ctl_addr == A_OFS_LO;
  wire w_ohi  = ctl_w && ctl_addr == A_OFS_HI;
  wire w_clo  = ctl_w && ctl_addr == A_CMP_LO;
  wire w_chi  = ctl_w && ctl_addr == A_CMP_HI;
  wire kick   = ref_vld && ref_wr && ref_addr == A_KICK;
  wire rearm  = kick | w_ctrl | w_olo | w_ohi;

  wire                en_nx     = w_ctrl ? ctl_wdata[0] : en_q;
  wire [31:0]         ofs_lo_nx = w_olo ? ctl_wdata : ofs_lo_q;
  wire [OFS_HI_W-1:0] ofs_hi_nx = w_ohi ? ctl_wdata[OFS_HI_W-1:0] : ofs_hi_q;
  wire [OFS_W-1:0]    ofs_nx    = {ofs_hi_nx, ofs_lo_nx};
  wire [CNT_W-1:0]    new_dl    = cnt_i + CNT_W'(ofs_nx);
  wire                expire    = armed_q && !rearm && (cnt_i >= dl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; s1_q <= 1'b0; s2_q <= 1'b0; armed_q <= 1'b0;
      ofs_lo_q <= '0; ofs_hi_q <= '0; dl_q <= '0; cmp_q <= '0;
      irq_o <= 1'b0; rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= 1'b0;
      if (w_olo) ofs_lo_q <= ctl_wdata;
      if (w_ohi) ofs_hi_q <= ctl_wdata[OFS_HI_W-1:0];
      if (rearm) begin
        en_q    <= en_nx;
        s1_q    <= 1'b0;
        s2_q    <= 1'b0;
        armed_q <= en_nx;
        if (en_nx) begin
          dl_q  <= new_dl;
          cmp_q <= new_dl;
        end
        if (w_ctrl | w_olo | w_ohi) irq_o <= 1'b0;
      end else if (expire) begin
        if (!s1_q) begin
          s1_q  <= 1'b1;
          irq_o <= 1'b1;
          dl_q  <= new_dl;
        end else begin
          s2_q      <= 1'b1;
          rst_req_o <= 1'b1;
          armed_q   <= 1'b0;
        end
      end
      if (w_clo) cmp_q[31:0]  <= ctl_wdata;
      if (w_chi) cmp_q[63:32] <= ctl_wdata;
    end
  end

  logic [31:0] ctl_mux, ref_mux;
  always_comb begin
    case (ctl_addr)
      A_CTRL:   ctl_mux = {29'b0, s2_q, s1_q, en_q};
      A_OFS_LO: ctl_mux = ofs_lo_q;
      A_OFS_HI: ctl_mux = 32'(ofs_hi_q);
      A_CMP_LO: ctl_mux = cmp_q[31:0];
      A_CMP_HI: ctl_mux = cmp_q[63:32];
      A_ID:     ctl_mux = ID_VAL;
      default:  ctl_mux = '0;
    endcase
    ref_mux = (ref_addr == A_ID) ? ID_VAL : '0;
  end
  assign ctl_rdata = (ctl_vld && !ctl_wr) ? ctl_mux : '0;
  assign ref_rdata = (ref_vld && !ref_wr) ? ref_mux : '0;

  AST_RSTREQ_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) rst_req_o |=> !rst_req_o);           // R9
  AST_RSTREQ_STAGE2: assert property (@(posedge clk) disable iff (!rst_n) rst_req_o |-> s2_q);                 // R9
  AST_CTRL_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (w_ctrl | w_olo | w_ohi) |=> !irq_o); // R4
  AST_KICK_CLEARS:   assert property (@(posedge clk) disable iff (!rst_n) kick |=> (!s1_q && !s2_q));          // R2
  AST_OFF_NO_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n) !en_q |=> !$rose(s1_q));             // R6
  AST_IRQ_STAGE1:    assert property (@(posedge clk) disable iff (!rst_n) $rose(irq_o) |-> s1_q);              // R8
endmodule

// File: tb/wdog_two_stage_bench.sv
module wdog_two_stage_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt = '0;
  logic        ref_vld = 0, ref_wr = 0, ctl_vld = 0, ctl_wr = 0;
  logic [11:0] ref_addr = '0, ctl_addr = '0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ref_rdata, ctl_rdata;
  logic        irq, rst_req;
  int checks = 0, errors = 0;
  bit done = 0;
  localparam logic [31:0] ID = 32'h0002_0A5D;

  always #5 clk = ~clk;

  wdog_two_stage u_wdog_two_stage (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt),
    .ref_vld(ref_vld), .ref_wr(ref_wr), .ref_addr(ref_addr), .ref_rdata(ref_rdata),
    .ctl_vld(ctl_vld), .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .irq_o(irq), .rst_req_o(rst_req));

  // op: 0 idle, 1 control write, 2 refresh write
  // fields: op[66:65] addr[64:53] data[52:21] cnt[20:5] irq[4] rstreq[3] status[2:0]
  localparam logic [66:0] VEC [12] = '{
    {2'd1, 12'h008, 32'd10,         16'd100,  1'b0, 1'b0, 3'd0},
    {2'd1, 12'h000, 32'd1,          16'd100,  1'b0, 1'b0, 3'd1},
    {2'd0, 12'h000, 32'd0,          16'd109,  1'b0, 1'b0, 3'd1},
    {2'd0, 12'h000, 32'd0,          16'd110,  1'b1, 1'b0, 3'd3},
    {2'd0, 12'h000, 32'd0,          16'd115,  1'b1, 1'b0, 3'd3},
    {2'd2, 12'h000, 32'd0,          16'd116,  1'b1, 1'b0, 3'd1},
    {2'd0, 12'h000, 32'd0,          16'd126,  1'b1, 1'b0, 3'd3},
    {2'd0, 12'h000, 32'd0,          16'd136,  1'b1, 1'b1, 3'd7},
    {2'd0, 12'h000, 32'd0,          16'd200,  1'b1, 1'b0, 3'd7},
    {2'd1, 12'h000, 32'hFFFF_FFFF,  16'd200,  1'b0, 1'b0, 3'd1},
    {2'd1, 12'h000, 32'd0,          16'd205,  1'b0, 1'b0, 3'd0},
    {2'd0, 12'h000, 32'd0,          16'd1000, 1'b0, 1'b0, 3'd0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic ctl_write(input logic [11:0] a, input logic [31:0] d);
    ctl_vld = 1; ctl_wr = 1; ctl_addr = a; ctl_wdata = d;
    tick();
    ctl_vld = 0; ctl_wr = 0;
  endtask

  task automatic kick();
    ref_vld = 1; ref_wr = 1; ref_addr = 12'h000;
    tick();
    ref_vld = 0; ref_wr = 0;
  endtask

  task automatic ctl_read(input logic [11:0] a, output logic [31:0] d);
    ctl_vld = 1; ctl_wr = 0; ctl_addr = a; #1;
    d = ctl_rdata; ctl_vld = 0; #1;
  endtask

  task automatic ref_read(input logic [11:0] a, output logic [31:0] d);
    ref_vld = 1; ref_wr = 0; ref_addr = a; #1;
    d = ref_rdata; ref_vld = 0; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk); #1;
    rst_n = 1; #1;

    // reset state
    ctl_read(12'h000, rd); check("R12 status", rd, 0);
    ctl_read(12'h008, rd); check("R12 ofs_lo", rd, 0);
    ctl_read(12'h00C, rd); check("R12 ofs_hi", rd, 0);
    ctl_read(12'h010, rd); check("R12 cmp_lo", rd, 0);
    ctl_read(12'h014, rd); check("R12 cmp_hi", rd, 0);
    check("R12 irq", irq, 0);
    check("R12 rstreq", rst_req, 0);
    ctl_read(12'hFFC, rd); check("R11 ctl id", rd, ID);
    ref_read(12'hFFC, rd); check("R11 ref id", rd, ID);

    // vector table: R2 R4 R5 R6 R8 R9
    for (int i = 0; i < 12; i++) begin
      cnt = 64'(VEC[i][20:5]);
      case (VEC[i][66:65])
        2'd1: begin ctl_vld = 1; ctl_wr = 1; ctl_addr = VEC[i][64:53]; ctl_wdata = VEC[i][52:21]; end
        2'd2: begin ref_vld = 1; ref_wr = 1; ref_addr = 12'h000; end
        default: ;
      endcase
      tick();
      ctl_vld = 0; ctl_wr = 0; ref_vld = 0; ref_wr = 0;
      check($sformatf("R8/R9 vec%0d irq", i), irq, VEC[i][4]);
      check($sformatf("R9 vec%0d rstreq", i), rst_req, VEC[i][3]);
      ctl_read(12'h000, rd);
      check($sformatf("R2/R4/R6 vec%0d status", i), rd, 64'(VEC[i][2:0]));
    end

    // R1: upper offset masking and 48-bit deadline
    cnt = 64'h10;
    ctl_write(12'h00C, 32'hABCD_0002);
    ctl_read(12'h00C, rd); check("R1 ofs_hi mask", rd, 32'h2);
    cnt = 64'h5;
    ctl_write(12'h000, 32'h1);
    ctl_read(12'h010, rd); check("R7 cmp_lo", rd, 32'hF);
    ctl_read(12'h014, rd); check("R1 R7 cmp_hi", rd, 32'h2);
    cnt = 64'h2_0000_000E; tick();
    ctl_read(12'h000, rd); check("R1 no early expiry", rd, 1);
    cnt = 64'h2_0000_000F; tick();
    ctl_read(12'h000, rd); check("R8 stage1 status", rd, 3);
    check("R8 irq", irq, 1);
    ctl_read(12'h010, rd); check("R8 cmp kept", rd, 32'hF);

    // R10: direct compare write affects readback only
    ctl_write(12'h010, 32'hFFFF_FFF0);
    ctl_read(12'h010, rd); check("R10 cmp readback", rd, 32'hFFFF_FFF0);
    cnt = 64'h4_0000_0018; tick();
    check("R10 no rstreq early", rst_req, 0);
    cnt = 64'h4_0000_0019; tick();
    check("R9 R10 rstreq at deadline", rst_req, 1);
    ctl_read(12'h000, rd); check("R9 stage2 status", rd, 7);

    // R3: refresh read, R11: unknown offsets
    ref_read(12'h000, rd); check("R3 refresh read zero", rd, 0);
    ctl_read(12'h000, rd); check("R3 status untouched", rd, 7);
    ctl_write(12'h040, 32'h0);
    ctl_read(12'h040, rd); check("R11 unknown read", rd, 0);
    ctl_read(12'h000, rd); check("R11 unknown write ignored", rd, 7);
    check("R11 irq kept", irq, 1);
    ref_vld = 1; ref_wr = 1; ref_addr = 12'h004; tick(); ref_vld = 0; ref_wr = 0;
    ctl_read(12'h000, rd); check("R11 ref unknown write ignored", rd, 7);

    // R5: offset write clears flags and irq, re-arms
    cnt = 64'h100;
    ctl_write(12'h008, 32'd20);
    check("R5 irq cleared", irq, 0);
    ctl_read(12'h000, rd); check("R5 status", rd, 1);
    ctl_read(12'h010, rd); check("R5 R7 cmp_lo", rd, 32'h114);
    ctl_read(12'h014, rd); check("R5 R7 cmp_hi", rd, 32'h2);

    // R2: refresh keeps irq
    cnt = 64'h200;
    ctl_write(12'h00C, 32'h0);
    cnt = 64'h214; tick();
    check("R8 irq again", irq, 1);
    cnt = 64'h220;
    kick();
    ctl_read(12'h000, rd); check("R2 status after kick", rd, 1);
    check("R2 irq kept", irq, 1);
    ctl_read(12'h010, rd); check("R2 R7 cmp after kick", rd, 32'h234);

    // R12: reset mid-run
    rst_n = 0; #2;
    check("R12 irq after reset", irq, 0);
    ctl_read(12'h000, rd); check("R12 status after reset", rd, 0);
    ctl_read(12'h008, rd); check("R12 ofs after reset", rd, 0);
    ref_read(12'hFFC, rd); check("R12 id after reset", rd, ID);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule